// File: doc/BRIEF.md
# One-Shot Management Route Table

This block holds a small set of egress-steering rules for control frames that the host CPU injects into a switch. Software loads a rule into a slot through a simple write port, giving a destination MAC address and a mask of egress ports, and sets the slot's armed bit in the same write. Every frame that enters from the CPU port has its destination MAC compared against all armed slots. When several armed slots match, the lowest-numbered one wins. Its port mask becomes the forwarding decision, and that slot disarms itself, so each rule serves exactly one frame.

Software reads the per-slot busy bits to learn when its frame has gone out. CPU-port frames that carry a reserved link-local destination address and hit no armed rule are dropped. Every other frame keeps the forwarding mask supplied by the normal lookup. The decision for a frame appears one clock after the frame is presented.

Top module: `mgmt_route_table`

## Requirements
- R1: There are 4 slots, each storing a 48-bit destination MAC, a 5-bit egress mask and an armed bit. A write with `cfg_we_i=1` loads the slot addressed by `cfg_slot_i`. The slot's armed bit takes the value of `cfg_arm_i`, so a write with `cfg_arm_i=0` disarms the slot. `busy_o[i]` shows slot i's armed bit from the cycle after the write.
- R2: A frame with `frm_from_cpu_i=0` is never compared against the slots and never consumes one. Its decision has hit=0, drop=0 and mask equal to `frm_fwd_mask_i`.
- R3: A CPU-port frame hits a slot only if the slot is armed and all 48 bits of its MAC equal `frm_dmac_i`. On a hit the decision has `dec_hit_o=1`, `dec_drop_o=0`, `dec_mask_o` set to the slot's mask and `dec_slot_o` set to the slot number.
- R4: When more than one armed slot matches, the lowest-numbered slot wins, and only that slot is consumed.
- R5: The winning slot's busy bit reads 0 in the cycle after the frame. An identical later frame no longer hits that slot.
- R6: A CPU-port frame that hits no slot and whose destination MAC has upper 44 bits equal to 0x0180C200000 (01-80-C2-00-00-00 to 01-80-C2-00-00-0F) gets `dec_drop_o=1` and `dec_mask_o=0`.
- R7: A CPU-port frame that hits no slot and is not link-local gets hit=0, drop=0 and mask equal to `frm_fwd_mask_i`.
- R8: When a write to a slot and a frame that consumes the same slot fall in the same cycle, the frame uses the old contents. The slot then holds the written values, including the written armed bit.
- R9: After reset all busy bits are 0 and `dec_valid_o` is 0.
- R10: A disarmed slot never matches, even when its stored MAC equals the frame's MAC.
- R11: `dec_valid_o` is high in exactly the cycle after each cycle with `frm_valid_i=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_slot_i | input | 2 | Slot index to write |
| cfg_dmac_i | input | 48 | Destination MAC to store |
| cfg_mask_i | input | 5 | Egress port mask to store |
| cfg_arm_i | input | 1 | Armed bit value to store |
| busy_o | output | 4 | Per-slot armed status |
| frm_valid_i | input | 1 | Frame header present this cycle |
| frm_from_cpu_i | input | 1 | Frame entered from the CPU port |
| frm_dmac_i | input | 48 | Frame destination MAC |
| frm_fwd_mask_i | input | 5 | Mask from the normal forwarding lookup |
| dec_valid_o | output | 1 | Decision valid, one cycle after the frame |
| dec_hit_o | output | 1 | Frame was steered by a slot |
| dec_drop_o | output | 1 | Frame is dropped |
| dec_mask_o | output | 5 | Final egress port mask |
| dec_slot_o | output | 2 | Winning slot number on a hit |

## Verification
Corrupt slot state shows up either as a hit on the wrong slot or mask, or as a busy bit that fails to clear. Both appear one cycle after the offending frame. A wrong armed bit can also stay hidden until a later frame with the same MAC arrives, and that frame then hits when it should miss, or misses when it should hit. For that reason the stimulus repeats identical MACs across several slots and frames, and it lines up a write and a consuming frame on the same slot in the same cycle. Priority and one-shot errors only show under such repetition.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int MAC_W = 48;
  // reserved link-local block 01-80-C2-00-00-0x
  localparam logic [MAC_W-5:0] LL_PREFIX = 44'h0180C200000;

  typedef enum logic [1:0] {
    DEC_PASS  = 2'd0,
    DEC_STEER = 2'd1,
    DEC_DROP  = 2'd2
  } dec_kind_e;
endpackage

// File: rtl/mrt_slot.sv
module mrt_slot
  import mrt_pkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 wr_arm_i,
  input  logic [MAC_W-1:0]     wr_dmac_i,
  input  logic [NUM_PORTS-1:0] wr_mask_i,
  input  logic                 probe_i,
  input  logic [MAC_W-1:0]     probe_dmac_i,
  input  logic                 consume_i,
  output logic                 match_o,
  output logic                 armed_o,
  output logic [NUM_PORTS-1:0] mask_o
);
  logic [MAC_W-1:0]     dmac_q;
  logic [NUM_PORTS-1:0] mask_q;
  logic                 armed_q;

  assign match_o = probe_i && armed_q && (dmac_q == probe_dmac_i);
  assign armed_o = armed_q;
  assign mask_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dmac_q  <= '0;
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_i) begin
        dmac_q  <= wr_dmac_i;
        mask_q  <= wr_mask_i;
        armed_q <= wr_arm_i;   // write beats same-cycle consumption
      end else if (consume_i) begin
        armed_q <= 1'b0;
      end
    end
  end

  AST_CONSUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !wr_i |=> !armed_o) else $error("slot not disarmed"); // R5
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> armed_o == $past(wr_arm_i)) else $error("write lost"); // R8
  AST_CONSUME_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> armed_o) else $error("disarmed slot consumed"); // R10
endmodule

// File: rtl/mrt_prio.sv
module mrt_prio #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end

  always_comb begin
    AST_GNT_ONEHOT: assert ($onehot0(gnt_o)) else $error("multiple grants"); // R4
    AST_GNT_LOWEST: assert (((gnt_o - 1'b1) & req_i & {N{any_o}}) == '0) else $error("lower request skipped"); // R4
  end
endmodule

// File: rtl/mrt_decide.sv
module mrt_decide
  import mrt_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frm_valid_i,
  input  logic                 frm_from_cpu_i,
  input  logic [MAC_W-1:0]     frm_dmac_i,
  input  logic [NUM_PORTS-1:0] frm_fwd_mask_i,
  input  logic                 hit_i,
  input  logic [SLOT_W-1:0]    hit_slot_i,
  input  logic [NUM_PORTS-1:0] hit_mask_i,
  output logic                 dec_valid_o,
  output logic                 dec_hit_o,
  output logic                 dec_drop_o,
  output logic [NUM_PORTS-1:0] dec_mask_o,
  output logic [SLOT_W-1:0]    dec_slot_o
);
  dec_kind_e kind;
  logic      is_ll;

  assign is_ll = (frm_dmac_i[MAC_W-1:4] == LL_PREFIX);

  always_comb begin
    kind = DEC_PASS;
    if (frm_from_cpu_i) begin
      if (hit_i)      kind = DEC_STEER;
      else if (is_ll) kind = DEC_DROP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_hit_o   <= 1'b0;
      dec_drop_o  <= 1'b0;
      dec_mask_o  <= '0;
      dec_slot_o  <= '0;
    end else begin
      dec_valid_o <= frm_valid_i;
      if (frm_valid_i) begin
        dec_hit_o  <= (kind == DEC_STEER);
        dec_drop_o <= (kind == DEC_DROP);
        dec_slot_o <= hit_slot_i;
        unique case (kind)
          DEC_STEER: dec_mask_o <= hit_mask_i;
          DEC_DROP:  dec_mask_o <= '0;
          default:   dec_mask_o <= frm_fwd_mask_i;
        endcase
      end
    end
  end

  AST_DROP_NO_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_drop_o |-> dec_mask_o == '0) else $error("drop with ports"); // R6
  AST_PASS_UNCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && !frm_from_cpu_i |=> dec_valid_o && !dec_hit_o && !dec_drop_o
      && dec_mask_o == $past(frm_fwd_mask_i)) else $error("non-cpu frame altered"); // R2
  AST_HIT_NOT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_hit_o |-> !dec_drop_o) else $error("hit and drop"); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> dec_valid_o) else $error("decision missing"); // R11
endmodule

// File: rtl/mgmt_route_table.sv
module mgmt_route_table
  import mrt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_PORTS = 5,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [SLOT_W-1:0]    cfg_slot_i,
  input  logic [MAC_W-1:0]     cfg_dmac_i,
  input  logic [NUM_PORTS-1:0] cfg_mask_i,
  input  logic                 cfg_arm_i,
  output logic [NUM_SLOTS-1:0] busy_o,
  input  logic                 frm_valid_i,
  input  logic                 frm_from_cpu_i,
  input  logic [MAC_W-1:0]     frm_dmac_i,
  input  logic [NUM_PORTS-1:0] frm_fwd_mask_i,
  output logic                 dec_valid_o,
  output logic                 dec_hit_o,
  output logic                 dec_drop_o,
  output logic [NUM_PORTS-1:0] dec_mask_o,
  output logic [SLOT_W-1:0]    dec_slot_o
);
  logic                 probe;
  logic [NUM_SLOTS-1:0] match, gnt;
  logic                 any_hit;
  logic [SLOT_W-1:0]    hit_idx;
  logic [NUM_PORTS-1:0] slot_mask [NUM_SLOTS];
  logic [NUM_PORTS-1:0] hit_mask;

  assign probe = frm_valid_i && frm_from_cpu_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    mrt_slot #(.NUM_PORTS(NUM_PORTS)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (cfg_we_i && (cfg_slot_i == SLOT_W'(g))),
      .wr_arm_i     (cfg_arm_i),
      .wr_dmac_i    (cfg_dmac_i),
      .wr_mask_i    (cfg_mask_i),
      .probe_i      (probe),
      .probe_dmac_i (frm_dmac_i),
      .consume_i    (gnt[g]),
      .match_o      (match[g]),
      .armed_o      (busy_o[g]),
      .mask_o       (slot_mask[g])
    );
  end

  mrt_prio #(.N(NUM_SLOTS)) u_prio (
    .req_i (match),
    .gnt_o (gnt),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  always_comb begin
    hit_mask = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (gnt[i]) hit_mask |= slot_mask[i];
  end

  mrt_decide #(.NUM_PORTS(NUM_PORTS), .SLOT_W(SLOT_W)) u_decide (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frm_valid_i    (frm_valid_i),
    .frm_from_cpu_i (frm_from_cpu_i),
    .frm_dmac_i     (frm_dmac_i),
    .frm_fwd_mask_i (frm_fwd_mask_i),
    .hit_i          (any_hit),
    .hit_slot_i     (hit_idx),
    .hit_mask_i     (hit_mask),
    .dec_valid_o    (dec_valid_o),
    .dec_hit_o      (dec_hit_o),
    .dec_drop_o     (dec_drop_o),
    .dec_mask_o     (dec_mask_o),
    .dec_slot_o     (dec_slot_o)
  );

  AST_NO_HIT_OFF_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !probe |-> gnt == '0) else $error("consume without cpu frame"); // R2
  AST_BUSY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit && !cfg_we_i |=> busy_o == ($past(busy_o) & ~$past(gnt))) else $error("busy mismatch"); // R5
endmodule

// File: tb/tb_mgmt_route_table.sv
`timescale 1ns/1ps
module tb_mgmt_route_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic [47:0] cfg_dmac = '0;
  logic [4:0]  cfg_mask = '0;
  logic        cfg_arm = 1'b0;
  logic [3:0]  busy;
  logic        frm_valid = 1'b0, frm_cpu = 1'b0;
  logic [47:0] frm_dmac = '0;
  logic [4:0]  frm_fwd = '0;
  logic        dec_valid, dec_hit, dec_drop;
  logic [4:0]  dec_mask;
  logic [1:0]  dec_slot;

  always #4 clk = ~clk;

  mgmt_route_table dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot), .cfg_dmac_i(cfg_dmac),
    .cfg_mask_i(cfg_mask), .cfg_arm_i(cfg_arm), .busy_o(busy),
    .frm_valid_i(frm_valid), .frm_from_cpu_i(frm_cpu), .frm_dmac_i(frm_dmac),
    .frm_fwd_mask_i(frm_fwd),
    .dec_valid_o(dec_valid), .dec_hit_o(dec_hit), .dec_drop_o(dec_drop),
    .dec_mask_o(dec_mask), .dec_slot_o(dec_slot)
  );

  typedef struct {
    bit       hit;
    bit       drop;
    bit [4:0] mask;
    bit [1:0] slot;
    string    req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model of the slots
  bit [47:0] m_dmac [4];
  bit [4:0]  m_mask [4];
  bit        m_arm  [4];

  localparam bit [47:0] MAC_LL  = 48'h0180C200000E;
  localparam bit [47:0] MAC_B   = 48'h0180C2000021;
  localparam bit [47:0] MAC_C   = 48'h02AABBCCDD01;
  localparam bit [47:0] MAC_D   = 48'h0011223344FF;
  localparam bit [47:0] MAC_E   = 48'h0180C2000003;

  function automatic exp_t predict(bit cpu, bit [47:0] d, bit [4:0] fwd, string req);
    exp_t e;
    e.hit = 0; e.drop = 0; e.mask = fwd; e.slot = 0; e.req = req;
    if (cpu) begin
      for (int i = 3; i >= 0; i--)
        if (m_arm[i] && m_dmac[i] == d) begin
          e.hit = 1; e.mask = m_mask[i]; e.slot = 2'(i);
        end
      if (!e.hit && d[47:4] == 44'h0180C200000) begin
        e.drop = 1; e.mask = 0;
      end
      if (e.hit) m_arm[e.slot] = 0;
    end
    return e;
  endfunction

  // called aligned to a falling edge; returns on the next falling edge
  task automatic step(bit do_frm, bit cpu, bit [47:0] d, bit [4:0] fwd,
                      bit do_wr, bit [1:0] s, bit [47:0] wd, bit [4:0] wm, bit wa,
                      string req);
    frm_valid = do_frm; frm_cpu = cpu; frm_dmac = d; frm_fwd = fwd;
    cfg_we = do_wr; cfg_slot = s; cfg_dmac = wd; cfg_mask = wm; cfg_arm = wa;
    if (do_frm) q.push_back(predict(cpu, d, fwd, req));
    if (do_wr) begin
      m_dmac[s] = wd; m_mask[s] = wm; m_arm[s] = wa;
    end
    @(negedge clk);
    frm_valid = 0; cfg_we = 0;
  endtask

  task automatic wr(bit [1:0] s, bit [47:0] d, bit [4:0] m, bit a, string req);
    step(0, 0, 0, 0, 1, s, d, m, a, req);
  endtask

  task automatic frame(bit cpu, bit [47:0] d, bit [4:0] fwd, string req);
    step(1, cpu, d, fwd, 0, 0, 0, 0, 0, req);
  endtask

  task automatic check_busy(string req);
    bit [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = m_arm[i];
    checks++;
    if (busy !== e) begin
      errors++;
      $display("FAIL %s busy: actual=%b expected=%b", req, busy, e);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && dec_valid && !done) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected decision: actual=valid expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (dec_hit !== e.hit || dec_drop !== e.drop || dec_mask !== e.mask ||
            (e.hit && dec_slot !== e.slot)) begin
          errors++;
          $display("FAIL %s decision: actual hit=%b drop=%b mask=%b slot=%0d expected hit=%b drop=%b mask=%b slot=%0d",
                   e.req, dec_hit, dec_drop, dec_mask, dec_slot, e.hit, e.drop, e.mask, e.slot);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_dmac[i] = 0; m_mask[i] = 0; m_arm[i] = 0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (busy !== 4'b0 || dec_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual busy=%b valid=%b expected busy=0000 valid=0", busy, dec_valid);
    end
    rst_n = 1;
    @(negedge clk);

    wr(0, MAC_LL, 5'b00010, 1, "R1");
    check_busy("R1");
    wr(1, MAC_B, 5'b00100, 1, "R1");
    wr(2, MAC_LL, 5'b01000, 1, "R1");
    check_busy("R1");

    frame(0, MAC_LL, 5'b10000, "R2");        // non-cpu passes untouched
    check_busy("R2");
    frame(1, MAC_LL, 5'b11111, "R4");        // slot0 beats slot2
    check_busy("R5");
    frame(1, MAC_LL, 5'b11111, "R5");        // slot0 used, slot2 now
    check_busy("R5");
    frame(1, MAC_LL, 5'b11111, "R6");        // none left: link-local drop
    frame(1, MAC_C, 5'b00110, "R7");         // ordinary pass
    frame(1, MAC_B ^ 48'h1, 5'b00001, "R3"); // one bit off: no hit
    frame(1, MAC_B, 5'b00001, "R3");         // exact: slot1
    check_busy("R5");

    wr(3, MAC_D, 5'b10001, 0, "R10");
    frame(1, MAC_D, 5'b00011, "R10");        // disarmed never matches
    check_busy("R10");

    // R8: same-cycle write and consumption of slot3
    wr(3, MAC_D, 5'b10001, 1, "R8");
    step(1, 1, MAC_D, 5'b00000, 1, 3, MAC_E, 5'b01100, 1, "R8");
    check_busy("R8");
    frame(1, MAC_E, 5'b00000, "R8");         // new contents hit
    check_busy("R8");

    // R1: explicit disarm, then back-to-back frames R11
    wr(1, MAC_C, 5'b00001, 1, "R1");
    wr(1, MAC_C, 5'b00001, 0, "R1");
    check_busy("R1");
    frame(1, MAC_C, 5'b00010, "R1");
    wr(0, MAC_C, 5'b11000, 1, "R11");
    frame(1, MAC_C, 5'b00001, "R11");
    frame(1, MAC_C, 5'b00001, "R11");
    frame(0, MAC_C, 5'b10101, "R11");
    check_busy("R11");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing decisions: actual=%0d pending expected=0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule